// File: doc/BRIEF.md
# Self-Refresh Power-Down Sequencer

This block runs a one-way shutdown of a memory controller so that power can later be cut from the controller's core logic. Power management asks for a shutdown with a flush request. The sequencer then tells the request queues to flush and waits until they report that they have fully drained. It signals back that the queues are empty. After that it waits for power management's self-refresh request.

When the self-refresh request arrives, the sequencer visits each populated DRAM rank in ascending index order. It sends each rank a one-cycle self-refresh entry command and waits for that rank's done handshake before moving to the next rank. The handshake stands in for the real command encoding and timing. Once every populated rank has confirmed, the sequencer raises a self-refresh acknowledge. One cycle later it raises a flag that says core power may be removed.

The sequence cannot be reversed. After the queue flush is raised, only a hard reset returns the block to normal operation.

Top module: `sr_shutdown_seq`

## Requirements
- R1: After reset every output is low: queue flush, queues-empty, all rank commands, acknowledge and power-safe.
- R2: A flush request seen while idle raises `queue_flush_o` on the next cycle. It then stays high until reset, whatever the inputs do.
- R3: `queues_empty_o` rises exactly one cycle after `queues_empty_i` is seen high while the flush is waiting for the drain. It is never high before that.
- R4: `sr_req_i` has no effect until `queues_empty_o` is high. After that, it starts the rank command sequence on the next cycle.
- R5: Rank commands follow four rules. Each bit of `rank_sr_cmd_o` selects the rank with the same index. Each command is a one-cycle pulse with at most one bit set. Ranks are visited in ascending index order. The next command is issued only after the current rank's `rank_sr_done_i` bit is seen high, and done bits of other ranks do not advance the sequence.
- R6: A rank whose bit in `rank_populated_i` is 0 never receives a command and counts as done. With an all-zero mask, `sr_ack_o` rises on the cycle after `sr_req_i` is accepted.
- R7: `sr_ack_o` is high only when every populated rank has reported done. Once high, it stays high until reset.
- R8: `pwr_safe_o` rises exactly one cycle after `sr_ack_o` and then stays high until reset.
- R9: A flush request during an active sequence or after completion is ignored. It does not restart the sequence and causes no further rank command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| flush_req_i | input | 1 | Shutdown (flush) request from power management |
| queues_empty_i | input | 1 | Request queues report that they are fully drained |
| sr_req_i | input | 1 | Self-refresh request from power management |
| rank_populated_i | input | NUM_RANKS | Populated-rank mask, held static while out of reset |
| rank_sr_done_i | input | NUM_RANKS | Per-rank confirmation that the rank is in self-refresh |
| queue_flush_o | output | 1 | Flush command to the request queues |
| queues_empty_o | output | 1 | Drain complete, reported to power management |
| rank_sr_cmd_o | output | NUM_RANKS | One-cycle self-refresh entry command per rank |
| sr_ack_o | output | 1 | All populated ranks are in self-refresh |
| pwr_safe_o | output | 1 | Core-logic power may be removed |

## Verification
The assertions make three assumptions about the inputs. The populated-rank mask does not change while the block is out of reset. A rank's done bit stays high once it is raised, until the next reset. The queue drain report is a plain level. The acknowledge property depends on the sticky done bits.

The bench follows these rules. It sets the mask only during reset. Its rank responder latches each done bit and clears it only during reset. Its manual done drives in the out-of-order scenario also only ever set bits.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FLUSH     = 3'd1,
        ST_WAIT_EMPTY= 3'd2,
        ST_WAIT_SRQ  = 3'd3,
        ST_RANK_CMD  = 3'd4,
        ST_RANK_WAIT = 3'd5,
        ST_DONE      = 3'd6
    } srs_state_e;

endpackage

// File: rtl/srs_rank_pick.sv
// Finds the lowest populated rank whose index is at or above start_i.
module srs_rank_pick #(
    parameter int NUM_RANKS = 4,
    parameter int IDX_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    parameter int CNT_W     = $clog2(NUM_RANKS + 1)
) (
    input  logic [NUM_RANKS-1:0] mask_i,
    input  logic [CNT_W-1:0]     start_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o
);

    logic [NUM_RANKS-1:0] cand;

    for (genvar g = 0; g < NUM_RANKS; g++) begin : g_cand
        assign cand[g] = mask_i[g] && (CNT_W'(g) >= start_i);
    end

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int r = NUM_RANKS - 1; r >= 0; r--) begin
            if (cand[r]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/srs_fsm.sv
module srs_fsm
    import srs_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int IDX_W     = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    parameter int CNT_W     = $clog2(NUM_RANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_req_i,
    input  logic                 queues_empty_i,
    input  logic                 sr_req_i,
    input  logic [NUM_RANKS-1:0] rank_populated_i,
    input  logic [NUM_RANKS-1:0] rank_sr_done_i,
    input  logic                 pick_found_i,
    input  logic [IDX_W-1:0]     pick_idx_i,
    output logic [CNT_W-1:0]     pick_start_o,
    output logic                 queue_flush_o,
    output logic                 queues_empty_o,
    output logic [NUM_RANKS-1:0] rank_sr_cmd_o,
    output logic                 sr_ack_o
);

    typedef struct packed {
        srs_state_e       state;
        logic [IDX_W-1:0] idx;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    // Search from rank 0 on entry, from the rank after the current one later.
    always_comb begin
        if (r_q.state == ST_RANK_WAIT) begin
            pick_start_o = CNT_W'(r_q.idx) + CNT_W'(1);
        end else begin
            pick_start_o = '0;
        end
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (flush_req_i) r_d.state = ST_FLUSH;
            end
            ST_FLUSH: begin
                r_d.state = ST_WAIT_EMPTY;
            end
            ST_WAIT_EMPTY: begin
                if (queues_empty_i) r_d.state = ST_WAIT_SRQ;
            end
            ST_WAIT_SRQ: begin
                if (sr_req_i) begin
                    if (pick_found_i) begin
                        r_d.state = ST_RANK_CMD;
                        r_d.idx   = pick_idx_i;
                    end else begin
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_RANK_CMD: begin
                r_d.state = ST_RANK_WAIT;
            end
            ST_RANK_WAIT: begin
                if (rank_sr_done_i[r_q.idx]) begin
                    if (pick_found_i) begin
                        r_d.state = ST_RANK_CMD;
                        r_d.idx   = pick_idx_i;
                    end else begin
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                r_d = r_q;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.idx   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        queue_flush_o  = (r_q.state != ST_IDLE);
        queues_empty_o = (r_q.state == ST_WAIT_SRQ) || (r_q.state == ST_RANK_CMD) ||
                         (r_q.state == ST_RANK_WAIT) || (r_q.state == ST_DONE);
        sr_ack_o       = (r_q.state == ST_DONE);
        rank_sr_cmd_o  = '0;
        if (r_q.state == ST_RANK_CMD) rank_sr_cmd_o[r_q.idx] = 1'b1;
    end

    // R2: flush is never withdrawn once raised
    p_flush_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        queue_flush_o |=> queue_flush_o);

    // R3: drain report only follows an observed empty queue
    p_empty_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(queues_empty_o) |-> $past(queues_empty_i));

    // R4: no rank command before the drain report
    p_cmd_after_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|rank_sr_cmd_o) |-> queues_empty_o);

    // R5: commands are one-hot single-cycle pulses
    p_cmd_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rank_sr_cmd_o));
    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|rank_sr_cmd_o) |=> !(|rank_sr_cmd_o));

    // R6: unpopulated ranks never receive a command
    p_skip_unpop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_sr_cmd_o & ~rank_populated_i) == '0);

    // R7: acknowledge only with all populated ranks done, and it holds
    p_ack_all_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack_o |-> ((rank_sr_done_i & rank_populated_i) == rank_populated_i));
    p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_ack_o |=> sr_ack_o);

endmodule

// File: rtl/srs_pwr_hold.sv
// Registers the power-safe flag one cycle behind the acknowledge.
module srs_pwr_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_ack_i,
    output logic pwr_safe_o
);

    logic pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q | sr_ack_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_d;
    end

    assign pwr_safe_o = pwr_q;

    // R8: power-safe rises one cycle after the acknowledge and holds
    p_pwr_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_safe_o) |-> $past(sr_ack_i));
    p_pwr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_safe_o |=> pwr_safe_o);

endmodule

// File: rtl/sr_shutdown_seq.sv
module sr_shutdown_seq #(
    parameter int NUM_RANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush_req_i,
    input  logic                 queues_empty_i,
    input  logic                 sr_req_i,
    input  logic [NUM_RANKS-1:0] rank_populated_i,
    input  logic [NUM_RANKS-1:0] rank_sr_done_i,
    output logic                 queue_flush_o,
    output logic                 queues_empty_o,
    output logic [NUM_RANKS-1:0] rank_sr_cmd_o,
    output logic                 sr_ack_o,
    output logic                 pwr_safe_o
);

    localparam int IDX_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;
    localparam int CNT_W = $clog2(NUM_RANKS + 1);

    logic [CNT_W-1:0] pick_start;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    srs_rank_pick #(
        .NUM_RANKS(NUM_RANKS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_pick (
        .mask_i  (rank_populated_i),
        .start_i (pick_start),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    srs_fsm #(
        .NUM_RANKS(NUM_RANKS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush_req_i      (flush_req_i),
        .queues_empty_i   (queues_empty_i),
        .sr_req_i         (sr_req_i),
        .rank_populated_i (rank_populated_i),
        .rank_sr_done_i   (rank_sr_done_i),
        .pick_found_i     (pick_found),
        .pick_idx_i       (pick_idx),
        .pick_start_o     (pick_start),
        .queue_flush_o    (queue_flush_o),
        .queues_empty_o   (queues_empty_o),
        .rank_sr_cmd_o    (rank_sr_cmd_o),
        .sr_ack_o         (sr_ack_o)
    );

    srs_pwr_hold u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_ack_i   (sr_ack_o),
        .pwr_safe_o (pwr_safe_o)
    );

endmodule

// File: tb/tb_sr_shutdown_seq.sv
module tb_sr_shutdown_seq;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         flush_req, q_empty, sr_req;
    logic [N-1:0] mask, done;
    logic         queue_flush, queues_empty_o, sr_ack, pwr_safe;
    logic [N-1:0] cmd;

    int tests = 0, fails = 0, cycles = 0;
    int cmd_log [16];
    int cmd_cnt, pulse_err, early_ack;
    int cnt [N];
    logic [N-1:0] prev_cmd;
    logic resp_en;
    int delay = 3;

    always #2 clk = ~clk;

    sr_shutdown_seq #(.NUM_RANKS(N)) dut (
        .clk(clk), .rst_n(rst_n), .flush_req_i(flush_req), .queues_empty_i(q_empty),
        .sr_req_i(sr_req), .rank_populated_i(mask), .rank_sr_done_i(done),
        .queue_flush_o(queue_flush), .queues_empty_o(queues_empty_o),
        .rank_sr_cmd_o(cmd), .sr_ack_o(sr_ack), .pwr_safe_o(pwr_safe)
    );

    // Rank responder and command monitor, acting on the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (|cmd) begin
                for (int r = 0; r < N; r++) if (cmd[r] && cmd_cnt < 16) cmd_log[cmd_cnt] = r;
                cmd_cnt++;
                if (cmd == prev_cmd) pulse_err++;
            end
            prev_cmd = cmd;
            if (sr_ack && ((done & mask) != mask)) early_ack++;
            for (int r = 0; r < N; r++) begin
                if (resp_en && cmd[r]) cnt[r] = delay;
                else if (cnt[r] > 0) begin
                    cnt[r]--;
                    if (cnt[r] == 0) done[r] = 1'b1;
                end
            end
        end
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog: run hung act=%0d exp<20000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset(input logic [N-1:0] m);
        rst_n = 1'b0;
        flush_req = 0; q_empty = 0; sr_req = 0;
        mask = m; done = '0; resp_en = 1'b1;
        cmd_cnt = 0; pulse_err = 0; early_ack = 0; prev_cmd = '0;
        for (int r = 0; r < N; r++) cnt[r] = 0;
        tick(3);
        rst_n = 1'b1;
        tick();
    endtask

    // Drives flush, drain and self-refresh request up to the first command.
    task automatic reach_ranks();
        flush_req = 1; tick(); flush_req = 0;
        tick();
        q_empty = 1; tick();
        sr_req = 1; tick(); sr_req = 0;
    endtask

    task automatic wait_ack(input int max);
        for (int i = 0; i < max && !sr_ack; i++) tick();
    endtask

    task automatic t_reset();
        do_reset(4'hF);
        check({queue_flush, queues_empty_o, cmd, sr_ack, pwr_safe} == '0, "R1 reset outputs",
              {queue_flush, queues_empty_o, cmd, sr_ack, pwr_safe}, 0);
    endtask

    task automatic t_full();
        do_reset(4'hF);
        flush_req = 1; tick(); flush_req = 0;
        check(queue_flush == 1, "R2 flush raised", queue_flush, 1);
        sr_req = 1; tick(4); sr_req = 0;
        check(queues_empty_o == 0, "R3 no empty before drain", queues_empty_o, 0);
        check(cmd_cnt == 0, "R4 early sr_req ignored", cmd_cnt, 0);
        q_empty = 1; tick();
        check(queues_empty_o == 1, "R3 empty one cycle after drain", queues_empty_o, 1);
        check(queue_flush == 1, "R2 flush held", queue_flush, 1);
        sr_req = 1; tick(); sr_req = 0;
        check(cmd == 4'b0001, "R4 first command", cmd, 1);
        wait_ack(200);
        check(sr_ack == 1, "R7 ack reached", sr_ack, 1);
        check(pwr_safe == 0, "R8 power-safe not with ack", pwr_safe, 0);
        check(early_ack == 0, "R7 no ack before all done", early_ack, 0);
        check(cmd_cnt == 4, "R5 command count", cmd_cnt, 4);
        check(cmd_log[0] == 0 && cmd_log[1] == 1 && cmd_log[2] == 2 && cmd_log[3] == 3,
              "R5 ascending order", {cmd_log[0][3:0], cmd_log[1][3:0], cmd_log[2][3:0], cmd_log[3][3:0]},
              16'h0123);
        check(pulse_err == 0, "R5 single-cycle pulses", pulse_err, 0);
        tick();
        check(pwr_safe == 1, "R8 power-safe after ack", pwr_safe, 1);
        flush_req = 1; q_empty = 0; tick(5); flush_req = 0;
        check(cmd_cnt == 4, "R9 flush in done ignored", cmd_cnt, 4);
        check(sr_ack && pwr_safe && queue_flush, "R7 ack and power held", {sr_ack, pwr_safe, queue_flush}, 7);
    endtask

    task automatic t_sparse();
        do_reset(4'b1010);
        reach_ranks();
        wait_ack(200);
        check(sr_ack == 1, "R6 sparse ack", sr_ack, 1);
        check(cmd_cnt == 2 && cmd_log[0] == 1 && cmd_log[1] == 3, "R6 only populated ranks",
              {cmd_cnt[3:0], cmd_log[0][3:0], cmd_log[1][3:0]}, 12'h213);
    endtask

    task automatic t_none();
        do_reset(4'b0000);
        flush_req = 1; tick(); flush_req = 0;
        tick();
        q_empty = 1; tick();
        sr_req = 1; tick(); sr_req = 0;
        check(sr_ack == 1 && cmd_cnt == 0, "R6 empty mask acks at once", {sr_ack, cmd_cnt[3:0]}, 16);
    endtask

    task automatic t_no_abort();
        do_reset(4'hF);
        resp_en = 0;
        reach_ranks();
        tick();
        done[2] = 1'b1;
        tick(4);
        check(cmd_cnt == 1, "R5 other rank done ignored", cmd_cnt, 1);
        flush_req = 1; q_empty = 0; tick(2); flush_req = 0; tick(2);
        check(cmd_cnt == 1 && queue_flush == 1 && sr_ack == 0, "R9 flush mid-sequence ignored",
              {cmd_cnt[3:0], queue_flush, sr_ack}, 6'h6);
        resp_en = 1;
        done[0] = 1'b1;
        wait_ack(200);
        check(sr_ack == 1 && cmd_cnt == 4, "R5 completes after own done",
              {sr_ack, cmd_cnt[3:0]}, 5'h14);
        check(early_ack == 0, "R7 no early ack with out-of-order done", early_ack, 0);
    endtask

    initial begin
        t_reset();
        t_full();
        t_sparse();
        t_none();
        t_no_abort();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule